// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block creates the processor reset from two sources. The first is an undervoltage flag, the digital output of a supply-threshold comparator that sits outside the block. The second is an active-low manual reset input. That input may come from a push button, from other logic, or from a watchdog output that has been wired to it. Reset stays asserted for as long as either source is active. When both sources have gone quiet, reset stays asserted for a further fixed stretch interval and then releases.

The stretch length is a clock-cycle count parameter. Its default of 20,000,000 cycles gives 200 ms at 100 MHz, which lies inside the allowed 160 ms to 280 ms window. The same interval debounces the manual input: each new low level, including each bounce, reloads the full interval. The manual input passes through a two-flop synchronizer. The undervoltage flag is taken as already synchronous to the clock. Two outputs are produced, an active-low reset and its active-high complement, each from its own register. The block's synchronous reset starts it in the asserted state with the counter loaded, so a power-on stretch always occurs.

Top module: `supv_reset_gen`

## Requirements
- R1: While `uv_flag` is 1, `rst_out` is 1. It becomes 1 no later than the first rising edge after `uv_flag` rises.
- R2: While `mr_n` is 0, `rst_out` is 1. It becomes 1 at the third rising edge after `mr_n` falls, because two synchronizer stages and one output register lie on the path.
- R3: Assume `mr_n` has been high and `uv_flag` falls. `rst_out` stays 1 until the (STRETCH_CYCLES+1)th rising edge after the fall and clears at that edge.
- R4: Assume `uv_flag` is low and `mr_n` rises. `rst_out` stays 1 until the (STRETCH_CYCLES+3)th rising edge after the rise and clears at that edge.
- R5: `rst_n_out` is always the exact inverse of `rst_out`.
- R6: A manual low of at least 2 clock cycles, or an undervoltage pulse of 1 cycle, that arrives during a stretch restarts the full interval. Bounce on `mr_n` therefore extends reset and never shortens it.
- R7: When both sources are idle and the stretch has run out, `rst_out` stays 0. No other input can assert it.
- R8: The stretch counter reloads to STRETCH_CYCLES whenever a source is active, never exceeds that value, and otherwise only counts down by one.
- R9: While `rst` is high, `rst_out` is 1. After `rst` falls with both sources idle, release follows the R3 timing.
- R10: When both sources overlap, reset is released only after the last of them goes inactive, with the stretch timed from that last release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| uv_flag | input | 1 | Undervoltage flag, 1 = supply below threshold |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| rst_n_out | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |

## Verification
The checker checks on every cycle that the two outputs are complementary, that an undervoltage flag forces reset on the next edge, and that the counter only reloads to the full value or steps down by one without exceeding it. It also checks that reset never falls while a source was active a moment earlier. The exact release edge after each kind of source release can only be shown by the bench's scenarios. The same holds for the synchronizer latency on the manual input, the restart caused by bounce or by a short undervoltage pulse mid-stretch, overlapping sources, and the power-on stretch.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // 200 ms at a 100 MHz clock
  localparam int unsigned DEFAULT_STRETCH = 20_000_000;
  localparam int unsigned SYNC_STAGES     = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= RESET_VAL;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RESET_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/supv_stretch_cnt.sv
module supv_stretch_cnt #(
  parameter int unsigned STRETCH_CYCLES = 16,
  parameter int unsigned CW             = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic [CW-1:0] cnt,
  output logic          busy
);
  localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYCLES);

  always_ff @(posedge clk) begin
    if (rst || load)      cnt <= RELOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/supv_out_reg.sv
module supv_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic rst_hi,
  output logic rst_lo_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_hi   <= 1'b1;
      rst_lo_n <= 1'b0;
    end else begin
      rst_hi   <= hold;
      rst_lo_n <= ~hold;
    end
  end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = DEFAULT_STRETCH,
  parameter int unsigned SYNC_DEPTH     = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_flag,
  input  logic mr_n,
  output logic rst_n_out,
  output logic rst_out
);
  localparam int unsigned CW = cnt_width(STRETCH_CYCLES);

  logic          mr_sync_n;
  logic          src_active;
  logic [CW-1:0] cnt;
  logic          busy;

  supv_sync #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (mr_n),
    .q   (mr_sync_n)
  );

  assign src_active = uv_flag | ~mr_sync_n;

  supv_stretch_cnt #(.STRETCH_CYCLES(STRETCH_CYCLES), .CW(CW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (src_active),
    .cnt  (cnt),
    .busy (busy)
  );

  supv_out_reg u_out (
    .clk      (clk),
    .rst      (rst),
    .hold     (src_active | busy),
    .rst_hi   (rst_out),
    .rst_lo_n (rst_n_out)
  );
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int unsigned STRETCH_CYCLES = 16,
  parameter int unsigned CW             = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          uv_flag,
  input logic          mr_n,
  input logic          mr_sync_n,
  input logic [CW-1:0] cnt,
  input logic          rst_n_out,
  input logic          rst_out
);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_CYCLES);

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    rst_n_out == ~rst_out); // R5

  AST_UV_FORCES_RESET: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> rst_out); // R1

  AST_NO_RELEASE_UNDER_UV: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> !$past(uv_flag)); // R3

  AST_NO_RELEASE_UNDER_MR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> ($past(mr_n, 3) && $past(mr_sync_n))); // R4

  AST_RELOAD_ON_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (uv_flag || !mr_sync_n) |=> (cnt == FULL)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL); // R8

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == FULL || cnt == $past(cnt) - 1'b1)); // R8
endmodule

bind supv_reset_gen supv_reset_gen_chk #(
  .STRETCH_CYCLES(STRETCH_CYCLES),
  .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .uv_flag   (uv_flag),
  .mr_n      (mr_n),
  .mr_sync_n (mr_sync_n),
  .cnt       (cnt),
  .rst_n_out (rst_n_out),
  .rst_out   (rst_out)
);

// File: tb/tb_supv_reset_gen.sv
`timescale 1ns/1ps
module tb_supv_reset_gen;
  localparam int unsigned N = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv_flag = 1'b0;
  logic mr_n = 1'b1;
  logic rst_n_out, rst_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  supv_reset_gen #(.STRETCH_CYCLES(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .uv_flag   (uv_flag),
    .mr_n      (mr_n),
    .rst_n_out (rst_n_out),
    .rst_out   (rst_out)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       uv;
    logic       mrn;
    logic       exp;
    logic [7:0] waitn;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b1, 1'b1, 1'b1, 8'd1},       // R1 asserted after one edge
    '{4'd1,  1'b1, 1'b1, 1'b1, 8'd50},      // R1 held
    '{4'd3,  1'b0, 1'b1, 1'b1, 8'(N)},      // R3 still held after N edges
    '{4'd3,  1'b0, 1'b1, 1'b0, 8'd1},       // R3 clears at edge N+1
    '{4'd2,  1'b0, 1'b0, 1'b0, 8'd2},       // R2 not yet after two edges
    '{4'd2,  1'b0, 1'b0, 1'b1, 8'd1},       // R2 asserted at third edge
    '{4'd2,  1'b0, 1'b0, 1'b1, 8'd60},      // R2 held while low
    '{4'd4,  1'b0, 1'b1, 1'b1, 8'(N + 2)},  // R4 held through edge N+2
    '{4'd4,  1'b0, 1'b1, 1'b0, 8'd1},       // R4 clears at edge N+3
    '{4'd10, 1'b1, 1'b0, 1'b1, 8'd5},       // R10 both active
    '{4'd10, 1'b0, 1'b0, 1'b1, 8'(N + 10)}, // R10 uv gone, manual holds
    '{4'd10, 1'b0, 1'b1, 1'b1, 8'(N + 2)},  // R10 stretch from manual release
    '{4'd10, 1'b0, 1'b1, 1'b0, 8'd1},
    '{4'd10, 1'b0, 1'b0, 1'b1, 8'd5},       // R10 manual first
    '{4'd10, 1'b1, 1'b0, 1'b1, 8'd3},
    '{4'd10, 1'b1, 1'b1, 1'b1, 8'(N + 10)}, // R10 manual gone, uv holds
    '{4'd10, 1'b0, 1'b1, 1'b1, 8'(N)},      // R10 stretch from uv release
    '{4'd10, 1'b0, 1'b1, 1'b0, 8'd1}
  };

  task automatic check(input string tag, input logic exp);
    checks++;
    if (rst_out !== exp || rst_n_out !== ~exp) begin
      failures++;
      $display("FAIL %s: rst_out=%b rst_n_out=%b expected rst_out=%b rst_n_out=%b",
               tag, rst_out, rst_n_out, exp, ~exp);
    end
  endtask

  // called at a negedge; drives, waits w rising edges, checks at the next negedge
  task automatic step(input logic uv, input logic mrn, input int w,
                      input string tag, input logic exp);
    uv_flag = uv;
    mr_n    = mrn;
    repeat (w) @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9 power-on behaviour
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 during reset", 1'b1);
    check("R5 complement in reset", 1'b1);
    rst = 1'b0;
    step(1'b0, 1'b1, N, "R9 power-on stretch held", 1'b1);
    step(1'b0, 1'b1, 1, "R9 power-on stretch ends", 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].uv, VEC[i].mrn, int'(VEC[i].waitn),
           $sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
    end

    // R6 bounce on manual input restarts the interval
    step(1'b0, 1'b0, 2, "R6 bounce low 1", 1'b0);
    step(1'b0, 1'b1, 10, "R6 bounce high 1", 1'b1);
    step(1'b0, 1'b0, 2, "R6 bounce low 2", 1'b1);
    step(1'b0, 1'b1, N + 2, "R6 held from last bounce", 1'b1);
    step(1'b0, 1'b1, 1, "R6 clears after last bounce", 1'b0);

    // R6 / R8 one-cycle undervoltage pulse mid-stretch reloads the counter
    step(1'b1, 1'b1, 3, "R6 uv start", 1'b1);
    step(1'b0, 1'b1, 20, "R6 mid stretch", 1'b1);
    step(1'b1, 1'b1, 1, "R8 reload pulse", 1'b1);
    step(1'b0, 1'b1, N, "R8 full interval again", 1'b1);
    step(1'b0, 1'b1, 1, "R8 clears after reload", 1'b0);

    // R7 idle stays quiet, R5 complement
    step(1'b0, 1'b1, 200, "R7 idle stays released", 1'b0);
    check("R5 complement idle", 1'b0);

    // R9 reset mid-operation re-arms power-on stretch
    rst = 1'b1;
    step(1'b0, 1'b1, 2, "R9 reset re-asserts", 1'b1);
    rst = 1'b0;
    step(1'b0, 1'b1, N, "R9 re-arm held", 1'b1);
    step(1'b0, 1'b1, 1, "R9 re-arm ends", 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule